// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block turns a fast source pulse train into the clock set a processor and its peripherals need, shapes the board reset for the processor, and qualifies the wait-state request from two independent requesters. Everything runs on one fast system clock. The source, and every derived clock, is modelled as a level or pulse sampled on that clock, not as a real clock net. A select input picks either the internal oscillator pulses or the external frequency pulses as the source. The chosen source is repeated on a pass-through output. It is divided by three into a processor clock that is high for one source period in three. The processor clock is halved again into a peripheral clock with equal high and low times.

The active-low reset request is synchronised and then stretched into an active-high processor reset that is released only on a falling edge of the processor clock, well after the request goes away. Two requesters each present a ready level and an active-low enable. Either one, when enabled and ready, makes the combined ready output true. An active-low select chooses between a two-stage path, for slow logic that cannot meet a tight setup window, and a one-stage path. A clock-sync input clears and holds the dividers so that several of these generators can be started in step.

Top module: `clkrdy_gen`

## Requirements
- R1: `cpuClk` divides the selected source by three. After a divider clear it is high, and it changes only one system clock after a selected source pulse. Counting source pulses from the clear, it is high after n pulses exactly when n mod 3 is 0.
- R2: `periClk` is 0 after a divider clear and is 1 after n source pulses exactly when (n div 3) is odd. Its period is six source pulses and it has equal high and low times.
- R3: `oscOut` is high for one system clock, one clock after each selected source pulse, and low otherwise.
- R4: With `freqSel` = 0 the source is `oscTick`; with `freqSel` = 1 it is `extTick`. Pulses on the unselected input affect no output.
- R5: While `clkSync` is high, the dividers are held cleared (`cpuClk` = 1, `periClk` = 0) and source pulses are not counted. Counting restarts from zero after it falls.
- R6: While `resetReqN` is low, the block is reset asynchronously: `cpuRst` = 1, `cpuClk` = 1, `periClk` = 0, `ready` = 0, `oscOut` = 0.
- R7: After `resetReqN` rises, it passes through a two-flop synchroniser. `cpuRst` then stays 1 until the fifth falling edge of `cpuClk` (a source pulse taken while `cpuClk` is high) and falls at that edge. That leaves at least four full processor clocks.
- R8: The raw ready term is (`rdyA` and not `enAN`) or (`rdyB` and not `enBN`). Once inputs have been held for two processor clocks, `ready` equals it.
- R9: `ready` changes only at falling edges of `cpuClk`. With `asyncSelN` = 1 it loads the raw term at that edge. With `asyncSelN` = 0 it loads a first stage that captured the raw term at the latest rising edge of `cpuClk` (a source pulse taken while the divider is in its third phase).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | fast system clock |
| resetReqN | input | 1 | active-low reset request, asynchronous |
| freqSel | input | 1 | source select: 0 internal oscillator, 1 external |
| oscTick | input | 1 | internal oscillator pulse, one clock wide |
| extTick | input | 1 | external frequency pulse, one clock wide |
| clkSync | input | 1 | high clears and holds the dividers |
| asyncSelN | input | 1 | 0 two-stage ready path, 1 one-stage |
| rdyA | input | 1 | ready level of requester A |
| enAN | input | 1 | active-low enable of requester A |
| rdyB | input | 1 | ready level of requester B |
| enBN | input | 1 | active-low enable of requester B |
| oscOut | output | 1 | selected source repeated |
| cpuClk | output | 1 | processor clock, source divided by three |
| periClk | output | 1 | peripheral clock, processor clock halved |
| cpuRst | output | 1 | active-high processor reset |
| ready | output | 1 | qualified, synchronised ready |

## Verification
The assertions check on every cycle the local timing rules. `cpuClk` drops after a pulse taken in its high phase. Both clocks stay still without a source pulse. `oscOut` follows the selected pulse. A divider clear leaves `cpuClk` high and `periClk` low. `ready` moves only at a `cpuClk` fall, and `cpuRst` is released only at one. The bench scenarios alone can show the counting properties: the one-in-three and six-pulse periods, the fifth-fall release of reset, and the pipeline depth of each ready mode. The bench covers every ready/enable combination in both modes, both source selections with noise on the unused input, sync holds and a reset in mid-run.

// File: rtl/crg_pkg.sv
package crg_pkg;
  // Strobes from control to the divider/ready datapath.
  typedef struct packed {
    logic tick;   // one selected source pulse this cycle
    logic clear;  // force dividers to phase zero and hold
  } divCtl_t;
endpackage

// File: rtl/crg_ctrl.sv
module crg_ctrl
  import crg_pkg::*;
#(
  parameter int RST_SYNC = 2,
  parameter int RST_HOLD = 4
) (
  input  logic    clk,
  input  logic    resetReqN,
  input  logic    freqSel,
  input  logic    oscTick,
  input  logic    extTick,
  input  logic    clkSync,
  input  logic    cpuFall,
  output divCtl_t ctl,
  output logic    cpuRst
);
  localparam int CW = $clog2(RST_HOLD + 1);

  logic [RST_SYNC-1:0] syncChain;
  logic                reqActive;
  logic [CW-1:0]       fallCnt;

  // Reset request synchroniser: asserts at once, releases after RST_SYNC edges.
  always_ff @(posedge clk or negedge resetReqN) begin
    if (!resetReqN) syncChain <= '0;
    else            syncChain <= {syncChain[RST_SYNC-2:0], 1'b1};
  end

  assign reqActive = ~syncChain[RST_SYNC-1];

  always_comb begin
    ctl.tick  = freqSel ? extTick : oscTick;
    ctl.clear = reqActive | clkSync;
  end

  // Stretch: release on the (RST_HOLD+1)-th processor falling edge.
  always_ff @(posedge clk or negedge resetReqN) begin
    if (!resetReqN) begin
      cpuRst  <= 1'b1;
      fallCnt <= '0;
    end else if (reqActive) begin
      cpuRst  <= 1'b1;
      fallCnt <= '0;
    end else if (cpuRst && cpuFall) begin
      if (fallCnt == CW'(RST_HOLD)) cpuRst <= 1'b0;
      else                          fallCnt <= fallCnt + CW'(1);
    end
  end
endmodule

// File: rtl/crg_datapath.sv
module crg_datapath
  import crg_pkg::*;
#(
  parameter int CPU_DIV = 3
) (
  input  logic    clk,
  input  logic    resetReqN,
  input  divCtl_t ctl,
  input  logic    asyncSelN,
  input  logic    rdyA,
  input  logic    enAN,
  input  logic    rdyB,
  input  logic    enBN,
  output logic    oscOut,
  output logic    cpuClk,
  output logic    periClk,
  output logic    ready,
  output logic    cpuFall
);
  localparam int PW = $clog2(CPU_DIV);
  localparam logic [PW-1:0] LAST = PW'(CPU_DIV - 1);

  logic [PW-1:0] phase;
  logic          periPhase;
  logic          cpuRise;
  logic          readyRaw;
  logic          stageOne;
  logic          readyQ;

  always_ff @(posedge clk or negedge resetReqN) begin
    if (!resetReqN) begin
      oscOut    <= 1'b0;
      phase     <= '0;
      periPhase <= 1'b0;
    end else begin
      oscOut <= ctl.tick;
      if (ctl.clear) begin
        phase     <= '0;
        periPhase <= 1'b0;
      end else if (ctl.tick) begin
        if (phase == LAST) begin
          phase     <= '0;
          periPhase <= ~periPhase;
        end else begin
          phase <= phase + PW'(1);
        end
      end
    end
  end

  assign cpuClk  = (phase == '0);
  assign periClk = periPhase;
  assign cpuFall = ctl.tick & ~ctl.clear & (phase == '0);
  assign cpuRise = ctl.tick & ~ctl.clear & (phase == LAST);

  assign readyRaw = (rdyA & ~enAN) | (rdyB & ~enBN);

  always_ff @(posedge clk or negedge resetReqN) begin
    if (!resetReqN) begin
      stageOne <= 1'b0;
      readyQ   <= 1'b0;
    end else begin
      if (cpuRise) stageOne <= readyRaw;
      if (cpuFall) readyQ   <= asyncSelN ? readyRaw : stageOne;
    end
  end

  assign ready = readyQ;
endmodule

// File: rtl/clkrdy_gen.sv
module clkrdy_gen
  import crg_pkg::*;
#(
  parameter int CPU_DIV  = 3,
  parameter int RST_SYNC = 2,
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic resetReqN,
  input  logic freqSel,
  input  logic oscTick,
  input  logic extTick,
  input  logic clkSync,
  input  logic asyncSelN,
  input  logic rdyA,
  input  logic enAN,
  input  logic rdyB,
  input  logic enBN,
  output logic oscOut,
  output logic cpuClk,
  output logic periClk,
  output logic cpuRst,
  output logic ready
);
  divCtl_t ctl;
  logic    cpuFall;

  crg_ctrl #(.RST_SYNC(RST_SYNC), .RST_HOLD(RST_HOLD)) u_ctrl (
    .clk(clk), .resetReqN(resetReqN), .freqSel(freqSel),
    .oscTick(oscTick), .extTick(extTick), .clkSync(clkSync),
    .cpuFall(cpuFall), .ctl(ctl), .cpuRst(cpuRst)
  );

  crg_datapath #(.CPU_DIV(CPU_DIV)) u_dp (
    .clk(clk), .resetReqN(resetReqN), .ctl(ctl), .asyncSelN(asyncSelN),
    .rdyA(rdyA), .enAN(enAN), .rdyB(rdyB), .enBN(enBN),
    .oscOut(oscOut), .cpuClk(cpuClk), .periClk(periClk),
    .ready(ready), .cpuFall(cpuFall)
  );
endmodule

// File: rtl/clkrdy_chk.sv
module clkrdy_chk
  import crg_pkg::*;
(
  input logic    clk,
  input logic    resetReqN,
  input divCtl_t ctl,
  input logic    cpuFall,
  input logic    cpuClk,
  input logic    periClk,
  input logic    oscOut,
  input logic    cpuRst,
  input logic    ready
);
  // R1
  cpu_fall_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    (ctl.tick && !ctl.clear && cpuClk) |=> !cpuClk);

  // R2
  clk_still_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    (!ctl.tick && !ctl.clear) |=> ($stable(cpuClk) && $stable(periClk)));

  // R3
  osc_pulse_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    ctl.tick |=> oscOut);

  // R3
  osc_idle_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    !ctl.tick |=> !oscOut);

  // R5
  clear_hold_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    ctl.clear |=> (cpuClk && !periClk));

  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    $fell(cpuRst) |-> $past(cpuFall));

  // R9
  ready_edge_chk: assert property (@(posedge clk) disable iff (!resetReqN)
    !cpuFall |=> $stable(ready));
endmodule

bind clkrdy_gen clkrdy_chk u_chk (
  .clk(clk), .resetReqN(resetReqN), .ctl(ctl), .cpuFall(cpuFall),
  .cpuClk(cpuClk), .periClk(periClk), .oscOut(oscOut),
  .cpuRst(cpuRst), .ready(ready)
);

// File: tb/sim_clkrdy_gen.sv
`timescale 1ns/1ps
module sim_clkrdy_gen;
  logic clk = 1'b0;
  logic resetReqN = 1'b0;
  logic freqSel = 1'b0, oscTick = 1'b0, extTick = 1'b0, clkSync = 1'b0;
  logic asyncSelN = 1'b1, rdyA = 1'b0, enAN = 1'b1, rdyB = 1'b0, enBN = 1'b1;
  logic oscOut, cpuClk, periClk, cpuRst, ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state, derived from the requirements
  int   tickCount = 0;
  int   falls = 0;
  logic st1E = 1'b0;
  logic rdyE = 1'b0;
  logic oscE = 1'b0;

  always #5 clk = ~clk;

  clkrdy_gen u0 (
    .clk(clk), .resetReqN(resetReqN), .freqSel(freqSel), .oscTick(oscTick),
    .extTick(extTick), .clkSync(clkSync), .asyncSelN(asyncSelN),
    .rdyA(rdyA), .enAN(enAN), .rdyB(rdyB), .enBN(enBN),
    .oscOut(oscOut), .cpuClk(cpuClk), .periClk(periClk),
    .cpuRst(cpuRst), .ready(ready)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic rawReady();
    return (rdyA & ~enAN) | (rdyB & ~enBN);
  endfunction

  task automatic checkAll();
    chk("R1", "cpuClk", cpuClk, (tickCount % 3) == 0);
    chk("R2", "periClk", periClk, ((tickCount / 3) % 2) == 1);
    chk("R3,R4", "oscOut", oscOut, oscE);
    chk("R7", "cpuRst", cpuRst, falls < 5);
    chk("R9", "ready", ready, rdyE);
  endtask

  // One system clock: drive pulses, update the model at the edge, check after.
  task automatic step(input logic o, input logic e);
    logic sel;
    logic raw;
    oscTick = o;
    extTick = e;
    sel = freqSel ? e : o;
    raw = rawReady();
    @(posedge clk);
    oscE = sel;
    if (clkSync) begin
      tickCount = 0;
    end else if (sel) begin
      if ((tickCount % 3) == 2) st1E = raw;
      if ((tickCount % 3) == 0) begin
        rdyE = asyncSelN ? raw : st1E;
        if (falls < 5) falls++;
      end
      tickCount++;
    end
    @(negedge clk);
    oscTick = 1'b0;
    extTick = 1'b0;
    checkAll();
  endtask

  task automatic doReset();
    oscTick = 1'b0;
    extTick = 1'b0;
    resetReqN = 1'b0;
    #1;
    chk("R6", "cpuRst async", cpuRst, 1'b1);
    chk("R6", "cpuClk async", cpuClk, 1'b1);
    chk("R6", "periClk async", periClk, 1'b0);
    chk("R6", "ready async", ready, 1'b0);
    chk("R6", "oscOut async", oscOut, 1'b0);
    tickCount = 0; falls = 0; st1E = 1'b0; rdyE = 1'b0; oscE = 1'b0;
    repeat (3) @(negedge clk);
    resetReqN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "cpuRst during sync", cpuRst, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6", "cpuRst at reset", cpuRst, 1'b1);
    doReset();

    // R8/R9: every ready/enable combination in both sync modes, internal source
    freqSel = 1'b0;
    for (int asel = 0; asel < 2; asel++) begin
      asyncSelN = asel[0];
      for (int combo = 0; combo < 16; combo++) begin
        {rdyA, enAN, rdyB, enBN} = combo[3:0];
        for (int k = 0; k < 12; k++) step(k % 2 == 0, k % 3 == 0);
        chk("R8", "ready settled", ready, rawReady());
      end
    end

    // R4: external source, noise on the internal input
    freqSel = 1'b1;
    asyncSelN = 1'b1;
    {rdyA, enAN, rdyB, enBN} = 4'b1000;
    for (int k = 0; k < 60; k++) step(k % 2 == 1, (k % 4) != 3);
    chk("R8", "ready ext", ready, 1'b1);

    // R1/R2: source pulse gaps of 1..4 clocks
    for (int gap = 1; gap <= 4; gap++) begin
      for (int n = 0; n < 30; n++) begin
        step(1'b0, 1'b1);
        for (int g = 1; g < gap; g++) step(1'b0, 1'b0);
      end
    end

    // R5: sync hold clears and freezes the dividers
    step(1'b0, 1'b1);
    clkSync = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1);
      chk("R5", "cpuClk held", cpuClk, 1'b1);
      chk("R5", "periClk held", periClk, 1'b0);
    end
    clkSync = 1'b0;
    for (int k = 0; k < 20; k++) step(1'b0, k % 2 == 0);

    // R6/R7: reset in mid-run, then stretch count on the internal source
    freqSel = 1'b0;
    asyncSelN = 1'b0;
    doReset();
    for (int k = 0; k < 50; k++) step(k % 3 == 0, 1'b1);
    chk("R7", "cpuRst released", cpuRst, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule